// File: doc/BRIEF.md
# Vector Branch Condition and Link-Write Unit

This block decides the outcome of one conditional branch whose condition is spread over a vector of condition-register fields. A start pulse captures the instruction address, the vector length, the reduction mode, and two link controls. The unit then takes one element test result per cycle, in element order, and folds them into a single branch condition. In ALL mode the tests are AND-ed; in ANY mode they are OR-ed.

When the vector is finished, the unit raises a one-cycle done strobe. With the strobe it reports whether the branch is taken and whether the link register is written. The written value is the instruction address plus 8. The link write is produced once per instruction, at the end. Element tests that arrive later in the vector therefore never observe a link register that this instruction has already overwritten.

The two link controls select one of four policies:
- never write;
- always write;
- write only if the condition holds;
- write only if the condition fails.

A zero vector length is legal. It completes using the empty-reduction value: true for ALL, false for ANY.

Top module: `vbr_link_unit`

## Requirements
- R1: While reset is low and in the cycle after it is released, `busy_o`, `done_o`, `taken_o` and `lr_we_o` are all 0.
- R2: A `start_i` pulse while idle captures `cia_i`, `vl_i`, `all_mode_i`, `lk_i` and `lru_i`, and `busy_o` is 1 in the next cycle. Later changes of those inputs have no effect on the instruction's result. A `start_i` seen while busy is ignored.
- R3: While busy, one element is consumed on each clock edge at which `elem_valid_i` is 1. Cycles with `elem_valid_i` at 0 consume nothing, whatever `elem_test_i` holds. `done_o` is 1 for exactly the one cycle after the edge that consumes the last element, and `busy_o` is 0 in that cycle.
- R4: With `all_mode_i`=1 (ALL), `taken_o` during done is the AND of the consumed element tests.
- R5: With `all_mode_i`=0 (ANY), `taken_o` during done is the OR of the consumed element tests.
- R6: With `vl_i`=0, no element is consumed. `done_o` is 1 in the second cycle after the start edge, and `taken_o` equals the captured ALL/ANY select: 1 for ALL, 0 for ANY.
- R7: With `lk_i`=0 and `lru_i`=0, `lr_we_o` stays 0.
- R8: With `lk_i`=1 and `lru_i`=0, `lr_we_o` is 1 during done, whatever the condition.
- R9: With `lk_i`=1 and `lru_i`=1, `lr_we_o` during done equals `taken_o`.
- R10: With `lk_i`=0 and `lru_i`=1, `lr_we_o` during done is the inverse of `taken_o`.
- R11: `lr_we_o` is 1 only together with `done_o`, for at most one cycle per instruction. When it is 1, `lr_wdata_o` equals the captured address plus 8, modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start of an instruction (taken only when idle) |
| cia_i | input | ADDR_W | Current instruction address |
| vl_i | input | VL_W | Vector length, 0 allowed |
| all_mode_i | input | 1 | 1 = ALL (AND), 0 = ANY (OR) |
| lk_i | input | 1 | Link bit |
| lru_i | input | 1 | Link-update-qualified bit |
| elem_valid_i | input | 1 | Element test present this cycle |
| elem_test_i | input | 1 | Condition test result of the current element |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion strobe |
| taken_o | output | 1 | Branch condition result, valid with done |
| lr_we_o | output | 1 | Link register write enable, valid with done |
| lr_wdata_o | output | ADDR_W | Link register write data (address plus 8) |

## Verification
The assertions assume that element tests arrive only while the unit is busy. They also assume that the element count never exceeds the captured length, which the sequencer enforces itself by ending the instruction on the last element. The bench sweeps every vector length up to the maximum of a 3-bit length field, every test pattern for that length, both reduction modes and all four link policies. It inserts idle bubbles that carry a poisoning test value, and it raises a second start while busy. It changes the captured inputs right after the start edge, so that any result read live from the ports instead of the captured copy shows up as a mismatch.

// File: rtl/vbr_pkg.sv
// Package: shared state type for the vector branch link-write unit.
// Assumes nothing beyond being compiled before the modules that use it.
package vbr_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/vbr_elem_seq.sv
// Element sequencer: accepts a start while idle, then counts valid
// elements until the captured vector length is reached. A zero
// length finishes one cycle after the start edge.
// Assumes elem_valid_i is meaningful only while busy_o is high.
module vbr_elem_seq
    import vbr_pkg::*;
#(
    parameter int VL_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [VL_W-1:0] vl_i,
    input  logic            elem_valid_i,
    output logic            accept_o,
    output logic            busy_o,
    output logic            consume_o,
    output logic            finish_o,
    output logic            empty_o
);

    seq_state_e      state_q;
    logic [VL_W-1:0] count_q;
    logic [VL_W-1:0] vl_q;
    logic [VL_W-1:0] last_idx;

    // Index of the final element of the captured vector.
    assign last_idx = vl_q - VL_W'(1);

    // Decode of start acceptance, element consumption and completion.
    always_comb begin
        busy_o    = (state_q == SEQ_RUN);
        accept_o  = start_i && (state_q == SEQ_IDLE);
        empty_o   = (vl_q == '0);
        consume_o = busy_o && elem_valid_i && !empty_o;
        finish_o  = busy_o && (empty_o || (consume_o && (count_q == last_idx)));
    end

    // State, element counter and captured length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            count_q <= '0;
            vl_q    <= '0;
        end else if (accept_o) begin
            state_q <= SEQ_RUN;
            count_q <= '0;
            vl_q    <= vl_i;
        end else if (finish_o) begin
            state_q <= SEQ_IDLE;
        end else if (consume_o) begin
            count_q <= count_q + VL_W'(1);
        end
    end

    // R3: counter never passes the captured length while running.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (empty_o || (count_q < vl_q)));

    // R2: an accepted start puts the sequencer into the running state.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> busy_o);

    // R6: a zero-length vector completes in its first running cycle.
    a_r6_empty_finishes: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && empty_o) |-> finish_o);

endmodule

// File: rtl/vbr_cond_fold.sv
// Condition fold: keeps a running AND (ALL mode) or OR (ANY mode)
// of element tests. It is seeded with the identity of the chosen
// mode, so an empty vector yields 1 for ALL and 0 for ANY.
// Assumes init_i and step_i are never high together.
module vbr_cond_fold (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic mode_all_i,
    input  logic step_i,
    input  logic test_i,
    input  logic empty_i,
    output logic cond_o
);

    logic all_q;
    logic acc_q;
    logic fold;

    // Combine the running value with the current element test.
    assign fold   = all_q ? (acc_q & test_i) : (acc_q | test_i);
    // Final condition: identity for empty vectors, else the fold.
    assign cond_o = empty_i ? acc_q : fold;

    // Seed on start, accumulate on each consumed element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            all_q <= 1'b0;
            acc_q <= 1'b0;
        end else if (init_i) begin
            all_q <= mode_all_i;
            acc_q <= mode_all_i;
        end else if (step_i) begin
            acc_q <= fold;
        end
    end

    // R4: once an AND fold has dropped to 0 it stays 0.
    a_r4_and_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (all_q && !acc_q && !init_i) |=> !acc_q);

    // R5: once an OR fold has risen to 1 it stays 1.
    a_r5_or_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_q && acc_q && !init_i) |=> acc_q);

endmodule

// File: rtl/vbr_link_policy.sv
// Link policy: chooses whether the link register is written from
// the link bit, the qualified-update bit and the branch condition.
// Purely combinational; assumes all three inputs are stable.
module vbr_link_policy (
    input  logic lk_i,
    input  logic lru_i,
    input  logic cond_i,
    output logic we_o
);

    // Four policies: never, always, on success, on failure.
    always_comb begin
        unique case ({lru_i, lk_i})
            2'b00:   we_o = 1'b0;
            2'b01:   we_o = 1'b1;
            2'b11:   we_o = cond_i;
            default: we_o = !cond_i;
        endcase
    end

endmodule

// File: rtl/vbr_link_unit.sv
// Vector branch condition and link-write unit (top). It captures the
// instruction fields on start, folds per-element tests, and issues a
// single registered done/taken/link-write pulse at completion.
// Assumes element tests are presented in element order, one per valid cycle.
module vbr_link_unit #(
    parameter int ADDR_W   = 32,
    parameter int VL_W     = 3,
    parameter int LINK_OFS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] cia_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic              all_mode_i,
    input  logic              lk_i,
    input  logic              lru_i,
    input  logic              elem_valid_i,
    input  logic              elem_test_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              taken_o,
    output logic              lr_we_o,
    output logic [ADDR_W-1:0] lr_wdata_o
);

    localparam logic [ADDR_W-1:0] LinkOfs = ADDR_W'(LINK_OFS);

    logic              accept;
    logic              consume;
    logic              finish;
    logic              empty;
    logic              cond;
    logic              we_next;
    logic [ADDR_W-1:0] cia_q;
    logic              lk_q;
    logic              lru_q;
    logic              done_q;
    logic              taken_q;
    logic              we_q;

    vbr_elem_seq #(
        .VL_W (VL_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .vl_i         (vl_i),
        .elem_valid_i (elem_valid_i),
        .accept_o     (accept),
        .busy_o       (busy_o),
        .consume_o    (consume),
        .finish_o     (finish),
        .empty_o      (empty)
    );

    vbr_cond_fold u_fold (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (accept),
        .mode_all_i (all_mode_i),
        .step_i     (consume),
        .test_i     (elem_test_i),
        .empty_i    (empty),
        .cond_o     (cond)
    );

    vbr_link_policy u_policy (
        .lk_i   (lk_q),
        .lru_i  (lru_q),
        .cond_i (cond),
        .we_o   (we_next)
    );

    // Capture the instruction address and link controls on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cia_q <= '0;
            lk_q  <= 1'b0;
            lru_q <= 1'b0;
        end else if (accept) begin
            cia_q <= cia_i;
            lk_q  <= lk_i;
            lru_q <= lru_i;
        end
    end

    // Register the single completion pulse and its results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            taken_q <= 1'b0;
            we_q    <= 1'b0;
        end else begin
            done_q  <= finish;
            taken_q <= finish && cond;
            we_q    <= finish && we_next;
        end
    end

    assign done_o     = done_q;
    assign taken_o    = taken_q;
    assign lr_we_o    = we_q;
    assign lr_wdata_o = cia_q + LinkOfs;

    // R11: done lasts one cycle.
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: link write only with done.
    a_r11_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we_o |-> done_o);

    // R3: done is reported only after the sequencer has gone idle.
    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7: no write when both link controls are clear.
    a_r7_never: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_q && !lru_q) |-> !lr_we_o);

    // R9: qualified update with link bit follows the condition.
    a_r9_on_success: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && lk_q && lru_q) |-> (lr_we_o == taken_o));

    // R10: qualified update without link bit follows the inverse.
    a_r10_on_failure: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !lk_q && lru_q) |-> (lr_we_o != taken_o));

endmodule

// File: tb/test_vbr_link_unit.sv
// Bench: sweeps lengths, patterns, modes and link policies; expected
// values are computed arithmetically from the requirements.
module test_vbr_link_unit;

    localparam int ADDR_W = 32;
    localparam int VL_W   = 3;
    localparam int MAX_VL = (1 << VL_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] cia_i = '0;
    logic [VL_W-1:0]   vl_i = '0;
    logic              all_mode_i = 1'b0;
    logic              lk_i = 1'b0;
    logic              lru_i = 1'b0;
    logic              elem_valid_i = 1'b0;
    logic              elem_test_i = 1'b0;
    logic              busy_o;
    logic              done_o;
    logic              taken_o;
    logic              lr_we_o;
    logic [ADDR_W-1:0] lr_wdata_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    vbr_link_unit #(.ADDR_W(ADDR_W), .VL_W(VL_W), .LINK_OFS(8)) i_vbr_link_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cia_i(cia_i), .vl_i(vl_i),
        .all_mode_i(all_mode_i), .lk_i(lk_i), .lru_i(lru_i),
        .elem_valid_i(elem_valid_i), .elem_test_i(elem_test_i),
        .busy_o(busy_o), .done_o(done_o), .taken_o(taken_o),
        .lr_we_o(lr_we_o), .lr_wdata_o(lr_wdata_o)
    );

    task automatic check(input bit ok, input string req, input logic [ADDR_W-1:0] act,
                         input logic [ADDR_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_instr(input logic [ADDR_W-1:0] cia, input int vl, input int pat,
                             input bit all, input bit lk, input bit lru);
        int  mask;
        bit  exp_taken;
        bit  exp_we;
        string pol;
        mask = (1 << vl) - 1;
        exp_taken = all ? ((pat & mask) == mask) : ((pat & mask) != 0);
        case ({lru, lk})
            2'b00: begin exp_we = 1'b0;       pol = "R7"; end
            2'b01: begin exp_we = 1'b1;       pol = "R8"; end
            2'b11: begin exp_we = exp_taken;  pol = "R9"; end
            default: begin exp_we = !exp_taken; pol = "R10"; end
        endcase
        start_i = 1'b1; cia_i = cia; vl_i = VL_W'(vl);
        all_mode_i = all; lk_i = lk; lru_i = lru; elem_valid_i = 1'b0;
        tick();
        // R2: scramble the inputs after capture; result must not move.
        start_i = 1'b0; cia_i = ~cia; vl_i = ~VL_W'(vl);
        all_mode_i = !all; lk_i = !lk; lru_i = !lru;
        check(busy_o == 1'b1, "R2 busy after start", ADDR_W'(busy_o), 1);
        check(done_o == 1'b0, "R3 no early done", ADDR_W'(done_o), 0);
        if (vl == 0) begin
            tick();
        end else begin
            for (int i = 0; i < vl; i++) begin
                if (i == 0 && pat[0]) begin
                    // R3: bubble with a poisoning test value.
                    elem_valid_i = 1'b0; elem_test_i = !all;
                    tick();
                    check(done_o == 1'b0 && busy_o == 1'b1, "R3 bubble consumes nothing",
                          ADDR_W'({busy_o, done_o}), 2);
                end
                elem_valid_i = 1'b1; elem_test_i = pat[i];
                if (i == 0 && !pat[1]) begin
                    start_i = 1'b1; cia_i = cia ^ 32'h0000_FFF0; vl_i = '0;
                end
                tick();
                start_i = 1'b0; elem_valid_i = 1'b0;
                if (i < vl - 1)
                    check(done_o == 1'b0, "R3 done not before last element", ADDR_W'(done_o), 0);
            end
        end
        check(done_o == 1'b1 && busy_o == 1'b0, vl == 0 ? "R6 empty done timing" : "R3 done timing",
              ADDR_W'({done_o, busy_o}), 2);
        check(taken_o == exp_taken, vl == 0 ? "R6 empty taken" : (all ? "R4 ALL taken" : "R5 ANY taken"),
              ADDR_W'(taken_o), ADDR_W'(exp_taken));
        check(lr_we_o == exp_we, pol, ADDR_W'(lr_we_o), ADDR_W'(exp_we));
        if (exp_we)
            check(lr_wdata_o == cia + 32'd8, "R11 link data", lr_wdata_o, cia + 32'd8);
        tick();
        check(done_o == 1'b0 && lr_we_o == 1'b0, "R11 single pulse",
              ADDR_W'({done_o, lr_we_o}), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int idx;
        idx = 0;
        @(negedge clk);
        tick();
        check({busy_o, done_o, taken_o, lr_we_o} == 4'b0, "R1 in reset",
              ADDR_W'({busy_o, done_o, taken_o, lr_we_o}), 0);
        rst_n = 1'b1;
        tick();
        check({busy_o, done_o, taken_o, lr_we_o} == 4'b0, "R1 after reset",
              ADDR_W'({busy_o, done_o, taken_o, lr_we_o}), 0);
        for (int vl = 0; vl <= MAX_VL; vl++)
            for (int pat = 0; pat < (1 << vl); pat++)
                for (int m = 0; m < 2; m++)
                    for (int cfg = 0; cfg < 4; cfg++) begin
                        idx++;
                        run_instr(ADDR_W'(idx) << 2, vl, pat, m[0], cfg[0], cfg[1]);
                    end
        // R11: address wrap of the link data.
        run_instr(32'hFFFF_FFFC, 2, 3, 1'b1, 1'b1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule